// File: doc/BRIEF.md
# Coherence Directory Slice with Forwarder Tracking

This block is one slice of a directory that is spread across the tiles of a 2D mesh. A cache that misses sends a query to the slice in its own tile. If the line's home slice is another tile, the slice relays the query to that slice unchanged. If this slice is the home, it looks up the line's entry and decides who supplies the data. A peer cache supplies it when one holds the line as the designated forwarder or as the modified owner. Otherwise the slice fetches the line from a memory port, and it picks which port from the line index.

Each entry holds four things: a line mode (uncached, shared or modified), a sharer vector with one bit per tile, a forwarder index with a valid bit, and the modified owner. After a forwarded read, the requester becomes the forwarder. The old supplier stays a plain sharer. A write invalidates every other sharer, one message per cycle. It then waits for one acknowledge per invalidation before it issues an exclusive memory fetch for the writer. An eviction from the modified owner sends a write-back to memory and leaves the line uncached. A line with an open read or write is marked busy until a completion response names it.

Top module: `coh_dir_slice`

## Requirements
- R1: After reset every line is uncached and idle. out_valid and rmt_valid are low, and q_ready is high for any local line.
- R2: A query whose q_home differs from SLICE_ID is accepted without touching the directory. In the next cycle rmt_valid is high and carries the same kind, requester, line and home. out_valid stays low.
- R3: A local read (q_kind 0) of an uncached line produces a memory read (out_kind 1) in the cycle after acceptance. out_memif equals the line index modulo N_MEMIF, and out_req and out_line echo the query.
- R4: A local read of a shared line whose forwarder is another tile produces a peer forward (out_kind 0) with out_tile set to that forwarder. The requester becomes the new forwarder, so the next read from a third tile is sent to it.
- R5: After a local read or write is accepted, that line is not ready until a completion (rsp_valid with rsp_ack 0) names it. Other lines stay ready meanwhile.
- R6: A local write (q_kind 1) sends one invalidate (out_kind 4) per cycle to each sharer other than the writer, in ascending tile order. It emits the exclusive fetch (out_kind 2) one cycle after the last acknowledge (rsp_ack 1) arrives. q_ready is low for all queries in between.
- R7: A write to a line that has no other sharer emits the exclusive fetch in the cycle after acceptance.
- R8: After a write, the forwarder is cleared. A read by another tile is forwarded to the modified owner, and the line becomes shared with the reader as forwarder.
- R9: An eviction (q_kind 2) from the modified owner emits a write-back (out_kind 3) to the line's memory port and leaves the line uncached, so the next read goes to memory.
- R10: An eviction from any tile that is not the modified owner produces no output and leaves the entry unchanged.
- R11: A read from the tile that is already the forwarder is served from memory, not by a peer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_valid | input | 1 | Query present |
| q_ready | output | 1 | Query can be accepted this cycle |
| q_kind | input | 2 | 0 read, 1 write, 2 eviction, 3 no-op |
| q_req | input | TILE_W | Requesting tile |
| q_line | input | LINE_W | Line index within the slice |
| q_home | input | TILE_W | Home slice of the line |
| out_valid | output | 1 | Message to a cache or memory port |
| out_kind | output | 3 | 0 peer forward, 1 memory read, 2 exclusive fetch, 3 write-back, 4 invalidate |
| out_tile | output | TILE_W | Target tile for peer forward or invalidate, else requester |
| out_memif | output | MEMIF_W | Memory port for the line |
| out_req | output | TILE_W | Tile that receives the data |
| out_line | output | LINE_W | Line index |
| rmt_valid | output | 1 | Relay to the home slice |
| rmt_kind | output | 2 | Relayed query kind |
| rmt_req | output | TILE_W | Relayed requester |
| rmt_line | output | LINE_W | Relayed line |
| rmt_home | output | TILE_W | Home slice to deliver to |
| rsp_valid | input | 1 | Response present |
| rsp_ack | input | 1 | 1 invalidate acknowledge, 0 transaction completion |
| rsp_line | input | LINE_W | Line a completion refers to |

## Verification
The properties assume that the caches follow the protocol. An acknowledge arrives only while a write is collecting them, and never more of them than invalidations were sent. A completion arrives only for a line with an open transaction. The bench keeps to this by running one transaction at a time against its own model of the directory. It returns exactly one acknowledge per observed invalidate, and it sends the completion only after the final message of a read or write. Stimulus mixes random kinds, tiles, lines and homes with directed sequences, and evictions are biased toward the current owner.

// File: rtl/coh_dir_pkg.sv
// Shared encodings for the coherence directory slice.
// Assumes: users cast port-level vectors to these enums.
package coh_dir_pkg;

    typedef enum logic [1:0] {
        QK_READ  = 2'd0,
        QK_WRITE = 2'd1,
        QK_EVICT = 2'd2,
        QK_NONE  = 2'd3
    } qkind_e;

    typedef enum logic [2:0] {
        OK_PEER   = 3'd0,
        OK_MEMRD  = 3'd1,
        OK_MEMRDX = 3'd2,
        OK_MEMWB  = 3'd3,
        OK_INVAL  = 3'd4
    } okind_e;

    typedef enum logic [1:0] {
        LM_IDLE = 2'd0,
        LM_SHR  = 2'd1,
        LM_MOD  = 2'd2
    } lmode_e;

endpackage

// File: rtl/coh_dir_array.sv
// Per-line directory storage: mode, sharer vector, forwarder and owner.
// Assumes: one combinational read port and one write port per cycle;
// N_LINES is a power of two.
module coh_dir_array
    import coh_dir_pkg::*;
#(
    parameter int N_TILES = 38,
    parameter int N_LINES = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [$clog2(N_LINES)-1:0] rd_line,
    output lmode_e                     rd_mode,
    output logic [N_TILES-1:0]         rd_sh,
    output logic                       rd_fv,
    output logic [$clog2(N_TILES)-1:0] rd_fid,
    output logic [$clog2(N_TILES)-1:0] rd_own,
    input  logic                       wr_en,
    input  logic [$clog2(N_LINES)-1:0] wr_line,
    input  lmode_e                     wr_mode,
    input  logic [N_TILES-1:0]         wr_sh,
    input  logic                       wr_fv,
    input  logic [$clog2(N_TILES)-1:0] wr_fid,
    input  logic [$clog2(N_TILES)-1:0] wr_own
);
    localparam int TILE_W = $clog2(N_TILES);

    lmode_e              mode_q [N_LINES];
    logic [N_TILES-1:0]  sh_q   [N_LINES];
    logic                fv_q   [N_LINES];
    logic [TILE_W-1:0]   fid_q  [N_LINES];
    logic [TILE_W-1:0]   own_q  [N_LINES];

    // Read port: present the addressed entry.
    always_comb begin
        rd_mode = mode_q[rd_line];
        rd_sh   = sh_q[rd_line];
        rd_fv   = fv_q[rd_line];
        rd_fid  = fid_q[rd_line];
        rd_own  = own_q[rd_line];
    end

    // Write port: clear all entries on reset, else update one entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_LINES; i++) begin
                mode_q[i] <= LM_IDLE;
                sh_q[i]   <= '0;
                fv_q[i]   <= 1'b0;
                fid_q[i]  <= '0;
                own_q[i]  <= '0;
            end
        end else if (wr_en) begin
            mode_q[wr_line] <= wr_mode;
            sh_q[wr_line]   <= wr_sh;
            fv_q[wr_line]   <= wr_fv;
            fid_q[wr_line]  <= wr_fid;
            own_q[wr_line]  <= wr_own;
        end
    end
endmodule

// File: rtl/coh_dir_decide.sv
// Combinational protocol decision for one local query against its entry.
// Assumes: the caller writes the new entry only when the query is accepted.
module coh_dir_decide
    import coh_dir_pkg::*;
#(
    parameter int N_TILES = 38
) (
    input  qkind_e                     q_kind,
    input  logic [$clog2(N_TILES)-1:0] q_req,
    input  lmode_e                     mode,
    input  logic [N_TILES-1:0]         sh,
    input  logic                       fv,
    input  logic [$clog2(N_TILES)-1:0] fid,
    input  logic [$clog2(N_TILES)-1:0] own,
    output logic                       upd,
    output lmode_e                     n_mode,
    output logic [N_TILES-1:0]         n_sh,
    output logic                       n_fv,
    output logic [$clog2(N_TILES)-1:0] n_fid,
    output logic [$clog2(N_TILES)-1:0] n_own,
    output logic                       emit,
    output okind_e                     ekind,
    output logic [$clog2(N_TILES)-1:0] etile,
    output logic                       hold,
    output logic                       start_wr,
    output logic [N_TILES-1:0]         victims
);
    localparam int TILE_W = $clog2(N_TILES);

    logic [N_TILES-1:0] req_bit;
    logic               tgt_v;
    logic [TILE_W-1:0]  tgt;

    // Supplier choice: the modified owner first, else the forwarder.
    always_comb begin
        req_bit = {{(N_TILES-1){1'b0}}, 1'b1} << q_req;
        tgt_v   = (mode == LM_MOD) || fv;
        tgt     = (mode == LM_MOD) ? own : fid;
        victims = sh & ~req_bit;
    end

    // Next entry and outgoing message for each query kind.
    always_comb begin
        upd      = 1'b0;
        n_mode   = mode;
        n_sh     = sh;
        n_fv     = fv;
        n_fid    = fid;
        n_own    = own;
        emit     = 1'b0;
        ekind    = OK_MEMRD;
        etile    = q_req;
        hold     = 1'b0;
        start_wr = 1'b0;
        case (q_kind)
            QK_READ: begin
                upd  = 1'b1;
                hold = 1'b1;
                emit = 1'b1;
                if (tgt_v && (tgt != q_req)) begin
                    ekind = OK_PEER;
                    etile = tgt;
                end
                n_mode = LM_SHR;
                n_sh   = sh | req_bit;
                n_fv   = 1'b1;
                n_fid  = q_req;
            end
            QK_WRITE: begin
                upd    = 1'b1;
                hold   = 1'b1;
                n_mode = LM_MOD;
                n_sh   = req_bit;
                n_own  = q_req;
                n_fv   = 1'b0;
                if (victims == '0) begin
                    emit  = 1'b1;
                    ekind = OK_MEMRDX;
                end else begin
                    start_wr = 1'b1;
                end
            end
            QK_EVICT: begin
                if ((mode == LM_MOD) && (own == q_req)) begin
                    upd    = 1'b1;
                    emit   = 1'b1;
                    ekind  = OK_MEMWB;
                    n_mode = LM_IDLE;
                    n_sh   = '0;
                    n_fv   = 1'b0;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/coh_dir_invseq.sv
// Write sequencer: sends invalidations lowest tile first, counts the
// acknowledges, then requests the exclusive fetch for the writer.
// Assumes: start only while idle; no more acknowledges than invalidations.
module coh_dir_invseq #(
    parameter int N_TILES = 38,
    parameter int N_LINES = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [N_TILES-1:0]         start_victims,
    input  logic [$clog2(N_TILES)-1:0] start_req,
    input  logic [$clog2(N_LINES)-1:0] start_line,
    input  logic                       ack,
    output logic                       act,
    output logic                       emit_inval,
    output logic [$clog2(N_TILES)-1:0] inval_tile,
    output logic                       emit_rdx,
    output logic [$clog2(N_TILES)-1:0] cur_req,
    output logic [$clog2(N_LINES)-1:0] cur_line
);
    localparam int TILE_W = $clog2(N_TILES);
    localparam int ACK_W  = $clog2(N_TILES + 1);

    logic [N_TILES-1:0] pend_q;
    logic [ACK_W-1:0]   acks_q;
    logic [ACK_W-1:0]   vic_cnt;
    logic               pend_any;

    // Lowest pending tile and the victim population count.
    always_comb begin
        inval_tile = '0;
        pend_any   = 1'b0;
        for (int i = 0; i < N_TILES; i++) begin
            if (pend_q[i] && !pend_any) begin
                inval_tile = TILE_W'(i);
                pend_any   = 1'b1;
            end
        end
        vic_cnt = '0;
        for (int i = 0; i < N_TILES; i++) begin
            vic_cnt = vic_cnt + ACK_W'(start_victims[i]);
        end
    end

    // Emit one invalidate per cycle, then the grant once all acks are in.
    always_comb begin
        emit_inval = act && pend_any;
        emit_rdx   = act && !pend_any && (acks_q == '0);
    end

    // Sequencer state: pending set, outstanding acks, transaction owner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act      <= 1'b0;
            pend_q   <= '0;
            acks_q   <= '0;
            cur_req  <= '0;
            cur_line <= '0;
        end else if (start) begin
            act      <= 1'b1;
            pend_q   <= start_victims;
            acks_q   <= vic_cnt;
            cur_req  <= start_req;
            cur_line <= start_line;
        end else if (act) begin
            if (pend_any) pend_q[inval_tile] <= 1'b0;
            if (ack && (acks_q != '0)) acks_q <= acks_q - 1'b1;
            if (emit_rdx) act <= 1'b0;
        end
    end
endmodule

// File: rtl/coh_dir_slice.sv
// Directory slice top: relays foreign queries, resolves local ones against
// the entry array, tracks busy lines and drives the registered message port.
// Assumes: N_LINES and N_MEMIF are powers of two, N_MEMIF >= 2.
module coh_dir_slice
    import coh_dir_pkg::*;
#(
    parameter int N_TILES  = 38,
    parameter int N_LINES  = 16,
    parameter int N_MEMIF  = 2,
    parameter int SLICE_ID = 5,
    localparam int TILE_W  = $clog2(N_TILES),
    localparam int LINE_W  = $clog2(N_LINES),
    localparam int MEMIF_W = $clog2(N_MEMIF)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               q_valid,
    output logic               q_ready,
    input  logic [1:0]         q_kind,
    input  logic [TILE_W-1:0]  q_req,
    input  logic [LINE_W-1:0]  q_line,
    input  logic [TILE_W-1:0]  q_home,
    output logic               out_valid,
    output logic [2:0]         out_kind,
    output logic [TILE_W-1:0]  out_tile,
    output logic [MEMIF_W-1:0] out_memif,
    output logic [TILE_W-1:0]  out_req,
    output logic [LINE_W-1:0]  out_line,
    output logic               rmt_valid,
    output logic [1:0]         rmt_kind,
    output logic [TILE_W-1:0]  rmt_req,
    output logic [LINE_W-1:0]  rmt_line,
    output logic [TILE_W-1:0]  rmt_home,
    input  logic               rsp_valid,
    input  logic               rsp_ack,
    input  logic [LINE_W-1:0]  rsp_line
);
    localparam logic [TILE_W-1:0] HOME_ID = TILE_W'(SLICE_ID);

    lmode_e             e_mode, n_mode;
    logic [N_TILES-1:0] e_sh, n_sh, victims;
    logic               e_fv, n_fv;
    logic [TILE_W-1:0]  e_fid, e_own, n_fid, n_own, etile;
    logic               upd, emit, hold, start_wr;
    okind_e             ekind;
    logic               seq_act, seq_inval, seq_rdx;
    logic [TILE_W-1:0]  seq_tile, seq_req;
    logic [LINE_W-1:0]  seq_line;
    logic [N_LINES-1:0] busy_q;
    logic               is_local, acc, acc_local;
    okind_e             out_kind_q;

    // Acceptance: foreign queries always pass; local ones wait on the line.
    always_comb begin
        is_local  = (q_home == HOME_ID);
        q_ready   = !seq_act && (!is_local || !busy_q[q_line]);
        acc       = q_valid && q_ready;
        acc_local = acc && is_local;
    end

    coh_dir_array #(.N_TILES(N_TILES), .N_LINES(N_LINES)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_line (q_line),
        .rd_mode (e_mode),
        .rd_sh   (e_sh),
        .rd_fv   (e_fv),
        .rd_fid  (e_fid),
        .rd_own  (e_own),
        .wr_en   (acc_local && upd),
        .wr_line (q_line),
        .wr_mode (n_mode),
        .wr_sh   (n_sh),
        .wr_fv   (n_fv),
        .wr_fid  (n_fid),
        .wr_own  (n_own)
    );

    coh_dir_decide #(.N_TILES(N_TILES)) u_decide (
        .q_kind   (qkind_e'(q_kind)),
        .q_req    (q_req),
        .mode     (e_mode),
        .sh       (e_sh),
        .fv       (e_fv),
        .fid      (e_fid),
        .own      (e_own),
        .upd      (upd),
        .n_mode   (n_mode),
        .n_sh     (n_sh),
        .n_fv     (n_fv),
        .n_fid    (n_fid),
        .n_own    (n_own),
        .emit     (emit),
        .ekind    (ekind),
        .etile    (etile),
        .hold     (hold),
        .start_wr (start_wr),
        .victims  (victims)
    );

    coh_dir_invseq #(.N_TILES(N_TILES), .N_LINES(N_LINES)) u_invseq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (acc_local && start_wr),
        .start_victims (victims),
        .start_req     (q_req),
        .start_line    (q_line),
        .ack           (rsp_valid && rsp_ack),
        .act           (seq_act),
        .emit_inval    (seq_inval),
        .inval_tile    (seq_tile),
        .emit_rdx      (seq_rdx),
        .cur_req       (seq_req),
        .cur_line      (seq_line)
    );

    // Busy bits: completion clears, a held local transaction sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= '0;
        end else begin
            if (rsp_valid && !rsp_ack) busy_q[rsp_line] <= 1'b0;
            if (acc_local && hold)     busy_q[q_line]   <= 1'b1;
        end
    end

    // Message port: the sequencer has priority, else the accepted query.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_kind_q <= OK_PEER;
            out_tile   <= '0;
            out_memif  <= '0;
            out_req    <= '0;
            out_line   <= '0;
        end else begin
            out_valid <= 1'b0;
            if (seq_inval || seq_rdx) begin
                out_valid  <= 1'b1;
                out_kind_q <= seq_inval ? OK_INVAL : OK_MEMRDX;
                out_tile   <= seq_inval ? seq_tile : seq_req;
                out_memif  <= MEMIF_W'(32'(seq_line) % N_MEMIF);
                out_req    <= seq_req;
                out_line   <= seq_line;
            end else if (acc_local && emit) begin
                out_valid  <= 1'b1;
                out_kind_q <= ekind;
                out_tile   <= etile;
                out_memif  <= MEMIF_W'(32'(q_line) % N_MEMIF);
                out_req    <= q_req;
                out_line   <= q_line;
            end
        end
    end

    assign out_kind = out_kind_q;

    // Relay port: copy a foreign query toward its home slice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rmt_valid <= 1'b0;
            rmt_kind  <= '0;
            rmt_req   <= '0;
            rmt_line  <= '0;
            rmt_home  <= '0;
        end else begin
            rmt_valid <= acc && !is_local;
            if (acc && !is_local) begin
                rmt_kind <= q_kind;
                rmt_req  <= q_req;
                rmt_line <= q_line;
                rmt_home <= q_home;
            end
        end
    end
endmodule

// File: rtl/coh_dir_slice_chk.sv
// Protocol checker for the directory slice, attached by bind.
// Assumes: caches send acks and completions only as the protocol allows.
module coh_dir_slice_chk #(
    parameter int N_TILES  = 38,
    parameter int N_LINES  = 16,
    parameter int N_MEMIF  = 2,
    parameter int SLICE_ID = 5,
    localparam int TILE_W  = $clog2(N_TILES),
    localparam int LINE_W  = $clog2(N_LINES),
    localparam int MEMIF_W = $clog2(N_MEMIF)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               q_valid,
    input logic               q_ready,
    input logic [1:0]         q_kind,
    input logic [TILE_W-1:0]  q_req,
    input logic [LINE_W-1:0]  q_line,
    input logic [TILE_W-1:0]  q_home,
    input logic               out_valid,
    input logic [2:0]         out_kind,
    input logic [TILE_W-1:0]  out_tile,
    input logic [MEMIF_W-1:0] out_memif,
    input logic [TILE_W-1:0]  out_req,
    input logic [LINE_W-1:0]  out_line,
    input logic               rmt_valid,
    input logic [1:0]         rmt_kind,
    input logic [TILE_W-1:0]  rmt_req,
    input logic [LINE_W-1:0]  rmt_line,
    input logic [TILE_W-1:0]  rmt_home
);
    localparam logic [TILE_W-1:0] HOME_ID = TILE_W'(SLICE_ID);

    assert_remote_relay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && q_ready && q_home != HOME_ID) |=>
        (rmt_valid && rmt_line == $past(q_line) && rmt_req == $past(q_req) &&
         rmt_kind == $past(q_kind) && rmt_home == $past(q_home) && !out_valid));

    assert_one_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && rmt_valid));

    assert_memrd_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 3'd1) |->
        $past(q_valid && q_ready && q_kind == 2'd0 && q_home == HOME_ID));

    assert_memif_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_kind == 3'd1 || out_kind == 3'd2 || out_kind == 3'd3)) |->
        (out_memif == MEMIF_W'(32'(out_line) % N_MEMIF)));

    assert_line_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q_valid && q_ready && q_home == HOME_ID && q_kind == 2'd0) |=>
        !(q_valid && q_ready && q_home == HOME_ID && q_line == $past(q_line)));

    assert_quiet_inval_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 3'd4) |-> !q_ready);

    assert_inval_spares_writer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 3'd4) |-> (out_tile != out_req));

    assert_wb_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_kind == 3'd3) |->
        $past(q_valid && q_ready && q_kind == 2'd2));
endmodule

bind coh_dir_slice coh_dir_slice_chk #(
    .N_TILES(N_TILES), .N_LINES(N_LINES), .N_MEMIF(N_MEMIF), .SLICE_ID(SLICE_ID)
) u_chk (
    .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_ready(q_ready),
    .q_kind(q_kind), .q_req(q_req), .q_line(q_line), .q_home(q_home),
    .out_valid(out_valid), .out_kind(out_kind), .out_tile(out_tile),
    .out_memif(out_memif), .out_req(out_req), .out_line(out_line),
    .rmt_valid(rmt_valid), .rmt_kind(rmt_kind), .rmt_req(rmt_req),
    .rmt_line(rmt_line), .rmt_home(rmt_home)
);

// File: tb/coh_dir_slice_bench.sv
// Self-checking bench: directed sequences plus seeded random traffic,
// compared against a behavioural directory model kept in the bench.
module coh_dir_slice_bench;
    localparam int NT  = 38;
    localparam int NL  = 16;
    localparam int NM  = 2;
    localparam int SID = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       q_valid = 1'b0;
    logic       q_ready;
    logic [1:0] q_kind = '0;
    logic [5:0] q_req = '0;
    logic [3:0] q_line = '0;
    logic [5:0] q_home = 6'(SID);
    logic       out_valid;
    logic [2:0] out_kind;
    logic [5:0] out_tile;
    logic [0:0] out_memif;
    logic [5:0] out_req;
    logic [3:0] out_line;
    logic       rmt_valid;
    logic [1:0] rmt_kind;
    logic [5:0] rmt_req;
    logic [3:0] rmt_line;
    logic [5:0] rmt_home;
    logic       rsp_valid = 1'b0;
    logic       rsp_ack = 1'b0;
    logic [3:0] rsp_line = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Model: mode 0 uncached, 1 shared, 2 modified.
    int          m_mode [NL];
    logic [NT-1:0] m_sh [NL];
    bit          m_fv   [NL];
    int          m_fid  [NL];
    int          m_own  [NL];

    always #4 clk = ~clk;

    coh_dir_slice #(.N_TILES(NT), .N_LINES(NL), .N_MEMIF(NM), .SLICE_ID(SID)) u_coh_dir_slice (
        .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_ready(q_ready),
        .q_kind(q_kind), .q_req(q_req), .q_line(q_line), .q_home(q_home),
        .out_valid(out_valid), .out_kind(out_kind), .out_tile(out_tile),
        .out_memif(out_memif), .out_req(out_req), .out_line(out_line),
        .rmt_valid(rmt_valid), .rmt_kind(rmt_kind), .rmt_req(rmt_req),
        .rmt_line(rmt_line), .rmt_home(rmt_home),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_line(rsp_line)
    );

    task automatic chk_eq(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int memif_of(input int line);
        return line % NM;
    endfunction

    // Present a query, wait for acceptance, return at the following negedge.
    task automatic issue(input int kind, input int req, input int line, input int home);
        @(negedge clk);
        q_valid = 1'b1;
        q_kind  = 2'(kind);
        q_req   = 6'(req);
        q_line  = 4'(line);
        q_home  = 6'(home);
        while (!q_ready) @(negedge clk);
        @(negedge clk);
        q_valid = 1'b0;
    endtask

    // Completion for a line, then the line must be ready again.
    task automatic send_done(input int line);
        rsp_valid = 1'b1;
        rsp_ack   = 1'b0;
        rsp_line  = 4'(line);
        @(negedge clk);
        rsp_valid = 1'b0;
        q_line = 4'(line);
        q_home = 6'(SID);
        #1;
        chk_eq("R5 ready after completion", int'(q_ready), 1);
    endtask

    // One full transaction checked against the model.
    task automatic run_txn(input int kind, input int req, input int line, input int home);
        logic [NT-1:0] rbit;
        logic [NT-1:0] vic;
        int tgt;
        bit tgt_v;
        int cnt;
        rbit = '0;
        rbit[req] = 1'b1;
        if (home != SID) begin
            issue(kind, req, line, home);
            chk_eq("R2 rmt_valid", int'(rmt_valid), 1);
            chk_eq("R2 rmt_line", int'(rmt_line), line);
            chk_eq("R2 rmt_req", int'(rmt_req), req);
            chk_eq("R2 rmt_kind", int'(rmt_kind), kind);
            chk_eq("R2 rmt_home", int'(rmt_home), home);
            chk_eq("R2 no local message", int'(out_valid), 0);
            return;
        end
        if (kind == 0) begin
            tgt_v = (m_mode[line] == 2) || m_fv[line];
            tgt   = (m_mode[line] == 2) ? m_own[line] : m_fid[line];
            issue(kind, req, line, home);
            chk_eq("R3 out_valid on read", int'(out_valid), 1);
            chk_eq("R3 out_req", int'(out_req), req);
            chk_eq("R3 out_line", int'(out_line), line);
            if (tgt_v && tgt != req) begin
                if (m_mode[line] == 2) begin
                    chk_eq("R8 forward to modified owner kind", int'(out_kind), 0);
                    chk_eq("R8 forward to modified owner tile", int'(out_tile), tgt);
                end else begin
                    chk_eq("R4 peer forward kind", int'(out_kind), 0);
                    chk_eq("R4 peer forward tile", int'(out_tile), tgt);
                end
            end else if (tgt_v) begin
                chk_eq("R11 self-forwarder reads memory", int'(out_kind), 1);
                chk_eq("R11 memif", int'(out_memif), memif_of(line));
            end else begin
                chk_eq("R3 memory read kind", int'(out_kind), 1);
                chk_eq("R3 memif", int'(out_memif), memif_of(line));
            end
            m_mode[line] = 1;
            m_sh[line]   = m_sh[line] | rbit;
            m_fv[line]   = 1;
            m_fid[line]  = req;
            send_done(line);
        end else if (kind == 1) begin
            vic = m_sh[line] & ~rbit;
            issue(kind, req, line, home);
            if (vic == '0) begin
                chk_eq("R7 immediate exclusive fetch", int'(out_valid), 1);
                chk_eq("R7 kind", int'(out_kind), 2);
                chk_eq("R7 out_req", int'(out_req), req);
            end else begin
                chk_eq("R6 nothing in accept cycle", int'(out_valid), 0);
                cnt = 0;
                for (int t = 0; t < NT; t++) begin
                    if (vic[t]) begin
                        cnt++;
                        @(negedge clk);
                        if (cnt == 1) begin
                            q_line = 4'((line + 1) % NL);
                            q_home = 6'(SID);
                            #1;
                            chk_eq("R6 all queries held", int'(q_ready), 0);
                        end
                        chk_eq("R6 invalidate valid", int'(out_valid), 1);
                        chk_eq("R6 invalidate kind", int'(out_kind), 4);
                        chk_eq("R6 invalidate tile order", int'(out_tile), t);
                    end
                end
                for (int k = 0; k < cnt; k++) begin
                    rsp_valid = 1'b1;
                    rsp_ack   = 1'b1;
                    rsp_line  = 4'(line);
                    @(negedge clk);
                    chk_eq("R6 no grant before all acks", int'(out_valid), 0);
                end
                rsp_valid = 1'b0;
                @(negedge clk);
                chk_eq("R6 grant after acks", int'(out_valid), 1);
                chk_eq("R6 grant kind", int'(out_kind), 2);
                chk_eq("R6 grant req", int'(out_req), req);
                chk_eq("R6 grant memif", int'(out_memif), memif_of(line));
            end
            m_mode[line] = 2;
            m_sh[line]   = rbit;
            m_own[line]  = req;
            m_fv[line]   = 0;
            send_done(line);
        end else if (kind == 2) begin
            issue(kind, req, line, home);
            if (m_mode[line] == 2 && m_own[line] == req) begin
                chk_eq("R9 write-back valid", int'(out_valid), 1);
                chk_eq("R9 write-back kind", int'(out_kind), 3);
                chk_eq("R9 write-back memif", int'(out_memif), memif_of(line));
                m_mode[line] = 0;
                m_sh[line]   = '0;
                m_fv[line]   = 0;
            end else begin
                chk_eq("R10 stray eviction silent", int'(out_valid), 0);
            end
        end
    endtask

    // Busy-line directed case.
    task automatic busy_case();
        issue(0, 12, 9, SID);
        chk_eq("R5 read issued", int'(out_valid), 1);
        m_mode[9] = 1; m_sh[9][12] = 1'b1; m_fv[9] = 1; m_fid[9] = 12;
        q_line = 4'd9; q_home = 6'(SID); #1;
        chk_eq("R5 same line held", int'(q_ready), 0);
        q_line = 4'd10; #1;
        chk_eq("R5 other line ready", int'(q_ready), 1);
        run_txn(0, 13, 10, SID);
        q_line = 4'd9; #1;
        chk_eq("R5 still held before completion", int'(q_ready), 0);
        send_done(9);
    endtask

    initial begin
        int seed;
        int r;
        int kind, req, line, home;
        seed = 20240;
        r = $urandom(seed);
        for (int i = 0; i < NL; i++) begin
            m_mode[i] = 0; m_sh[i] = '0; m_fv[i] = 0; m_fid[i] = 0; m_own[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R1 out_valid after reset", int'(out_valid), 0);
        chk_eq("R1 rmt_valid after reset", int'(rmt_valid), 0);
        chk_eq("R1 ready after reset", int'(q_ready), 1);

        run_txn(0, 10, 2, SID);
        run_txn(0, 11, 3, SID);
        run_txn(0, 20, 2, SID);
        run_txn(0, 30, 2, SID);
        run_txn(0, 30, 2, SID);
        run_txn(1, 10, 2, SID);
        run_txn(0, 7, 2, SID);
        run_txn(1, 4, 5, SID);
        run_txn(2, 9, 5, SID);
        run_txn(0, 6, 5, SID);
        run_txn(1, 3, 6, SID);
        run_txn(2, 3, 6, SID);
        run_txn(0, 8, 6, SID);
        run_txn(0, 1, 7, 11);
        run_txn(1, 2, 7, 0);
        busy_case();

        for (int n = 0; n < 400; n++) begin
            r    = int'($urandom % 10);
            line = int'($urandom % NL);
            req  = int'($urandom % NT);
            kind = (r < 5) ? 0 : (r < 8) ? 1 : 2;
            if (kind == 2 && m_mode[line] == 2 && ($urandom % 2) == 0) req = m_own[line];
            home = (($urandom % 10) == 0) ? (SID + 1 + int'($urandom % (NT - 1))) % NT : SID;
            run_txn(kind, req, line, home);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R1-run actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule